// File: doc/BRIEF.md
# BCD Clock Calendar Register Core

This block holds wall-clock time and a calendar as eight packed-BCD bytes and advances them by one hundredth of a second on every cycle in which its tick input is high. A prescaler outside the block supplies the tick at 100 Hz. The block handles 12-hour and 24-hour hour formats, month lengths and leap years. It also holds two control bits: one stops the count, and one enables an external reset input elsewhere in the system.

A host writes all eight bytes at once through a 64-bit parallel load port. It reads them through a snapshot port, where a one-cycle request copies every byte in the same clock edge. A read therefore never shows a carry that has reached only some of the bytes. The words on both ports use the same byte layout: byte k sits at bits 8k+7:8k.

Top module: `bcd_rtc_core`

## Requirements
- R1: After a synchronous reset, the snapshot output is all zero. A first snapshot then reads year 00, month 01, date 01, byte 4 = 0x01 (weekday 1, count running, reset-enable clear) and all time bytes 00. Both control outputs are low.
- R2: Each qualifying tick adds one to byte 0 (hundredths, BCD 00-99). Byte 0 wraps 99->00 and carries into byte 1 (seconds, 00-59). Byte 1 wraps 59->00 and carries into byte 2 (minutes, 00-59), which carries into the hours in the same way. A units digit of 9 carries into the tens digit.
- R3: Byte 3 bit 7 = 0 selects 24-hour mode. In that mode bits 5:0 are BCD hours 00-23, and 23->00 advances the date.
- R4: Byte 3 bit 7 = 1 selects 12-hour mode, with bits 4:0 holding hours 01-12 and bit 5 as the PM flag (1 = PM). The hour steps 11->12 and toggles the flag at that step. It steps 12->01 with the flag kept. Only the step from 11 PM to 12 AM advances the date.
- R5: Byte 5 holds the date and byte 6 the month (01-12). The date wraps to 01 and advances the month after 30 in April, June, September and November, and after 31 in the other months except February.
- R6: February ends at 29 when the BCD year in byte 7 is divisible by 4 (00 included), and at 28 otherwise.
- R7: Month 12 wraps to 01 and advances byte 7 (year 00-99). Year 99 wraps to 00.
- R8: Byte 4 bits 2:0 hold the weekday 1-7. It advances on every date rollover and wraps 7->1.
- R9: While byte 4 bit 5 (stop bit) is 1, ticks are ignored and every byte holds its value. The `osc_off` output shows this bit.
- R10: The unused bits always read 0 and discard written values. These are byte 1 bit 7, byte 2 bit 7, byte 3 bit 6, byte 4 bits 7, 6 and 3, byte 5 bits 7:6, and byte 6 bits 7:5.
- R11: A load in the same cycle as a tick stores the load word (with the R10 bits cleared) and drops the tick.
- R12: A snapshot request copies all eight bytes as they stood in the request cycle. The copy appears on the next cycle and holds, while the count runs on, until the next request.
- R13: Byte 4 bit 4 (reset-enable) is shown on the `rst_en` output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | 100 Hz advance strobe, one clock wide per hundredth |
| load_en | input | 1 | Write all eight bytes from load_data |
| load_data | input | 64 | Load word, byte k at bits 8k+7:8k |
| snap_req | input | 1 | Capture all bytes into snap_data |
| snap_data | output | 64 | Last captured word, same layout |
| osc_off | output | 1 | Stop bit (byte 4 bit 5) |
| rst_en | output | 1 | Reset-enable bit (byte 4 bit 4) |

## Verification
The hard cases are the rollovers deep in the carry chain: end of month, February in leap and common years, year 99, and the 11 PM step in 12-hour mode. Reaching any of them by counting from reset would take billions of ticks. Each scenario therefore loads a word one hundredth before the boundary, gives a single tick, and takes a snapshot. The stop bit and the snapshot hold are checked the same way, with long tick bursts between the load and the read.

// File: rtl/bcd_rtc_pkg.sv
// Package: shared layout constants and BCD helpers for the clock calendar core.
// Assumes all stored fields are valid packed BCD.
package bcd_rtc_pkg;
    localparam int REG_W  = 8;
    localparam int NREG   = 8;
    localparam int WORD_W = REG_W * NREG;

    // Byte order is the carry order, hundredths first.
    localparam int IDX_HUND = 0;
    localparam int IDX_SEC  = 1;
    localparam int IDX_MIN  = 2;
    localparam int IDX_HOUR = 3;
    localparam int IDX_CTL  = 4;
    localparam int IDX_DATE = 5;
    localparam int IDX_MON  = 6;
    localparam int IDX_YEAR = 7;

    // Bits that are stored in each byte; the rest read as zero.
    function automatic logic [REG_W-1:0] keep_mask(input int idx);
        case (idx)
            IDX_SEC, IDX_MIN: return 8'h7F;
            IDX_HOUR:         return 8'hBF;
            IDX_CTL:          return 8'h37;
            IDX_DATE:         return 8'h3F;
            IDX_MON:          return 8'h1F;
            default:          return 8'hFF;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] word_mask();
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < NREG; i++) begin
            m[i*REG_W +: REG_W] = keep_mask(i);
        end
        return m;
    endfunction

    // Two-digit BCD increment without wrap.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Year divisible by 4: (10*tens + units) mod 4 == (2*tens + units) mod 4.
    function automatic logic year_is_leap(input logic [7:0] yr);
        logic [3:0] s;
        s = yr[3:0] + {2'b00, yr[4], 1'b0};
        return (s[1:0] == 2'b00);
    endfunction

    // Last date of a month, in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic leap);
        case (mon)
            8'h02:                      return leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_clock_chain.sv
// Time-of-day counters: hundredths, seconds, minutes and hours, with 12/24-hour
// hour stepping. Produces the day carry for the calendar chain.
// Assumes ld has priority and that the ld_* values arrive already masked.
module rtc_clock_chain
    import bcd_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             ld,
    input  logic [REG_W-1:0] ld_hund,
    input  logic [REG_W-1:0] ld_sec,
    input  logic [REG_W-1:0] ld_min,
    input  logic [REG_W-1:0] ld_hour,
    output logic [REG_W-1:0] hund_q,
    output logic [REG_W-1:0] sec_q,
    output logic [REG_W-1:0] min_q,
    output logic [REG_W-1:0] hour_q,
    output logic             day_carry
);
    logic             c_sec, c_min, c_hr;
    logic [REG_W-1:0] hour_nx;
    logic [REG_W-1:0] h12, h24;
    logic             pm;

    // Carry ripple through the sub-hour digits.
    always_comb begin
        c_sec = adv && (hund_q >= 8'h99);
        c_min = c_sec && (sec_q >= 8'h59);
        c_hr  = c_min && (min_q >= 8'h59);
    end

    // Next hour value and day carry for both hour formats.
    always_comb begin
        h12 = {3'b000, hour_q[4:0]};
        h24 = {2'b00, hour_q[5:0]};
        pm  = hour_q[5];
        if (hour_q[7]) begin
            if (h12 == 8'h11)      hour_nx = {2'b10, ~pm, 5'h12};
            else if (h12 >= 8'h12) hour_nx = {2'b10, pm, 5'h01};
            else                   hour_nx = {2'b10, pm, 5'h00} | (bcd_inc(h12) & 8'h1F);
            day_carry = c_hr && (h12 == 8'h11) && pm;
        end else begin
            if (h24 >= 8'h23) hour_nx = 8'h00;
            else              hour_nx = bcd_inc(h24) & 8'h3F;
            day_carry = c_hr && (h24 >= 8'h23);
        end
    end

    // Register update: reset, load, then tick-driven advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hund_q <= '0;
            sec_q  <= '0;
            min_q  <= '0;
            hour_q <= '0;
        end else if (ld) begin
            hund_q <= ld_hund;
            sec_q  <= ld_sec;
            min_q  <= ld_min;
            hour_q <= ld_hour;
        end else begin
            if (adv)   hund_q <= (hund_q >= 8'h99) ? 8'h00 : bcd_inc(hund_q);
            if (c_sec) sec_q  <= (sec_q  >= 8'h59) ? 8'h00 : bcd_inc(sec_q);
            if (c_min) min_q  <= (min_q  >= 8'h59) ? 8'h00 : bcd_inc(min_q);
            if (c_hr)  hour_q <= hour_nx;
        end
    end

    // R2: seconds move only when hundredths roll over.
    p_sec_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && hund_q != 8'h99) |=> $stable(sec_q));

    // R3: 23:59:59.99 in 24-hour mode rolls to hour 00.
    p_midnight_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv && hund_q == 8'h99 && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23)
        |=> (hour_q == 8'h00));

    // R4: in 12-hour mode the step out of 11 lands on 12 with the PM flag flipped.
    p_noon_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && adv && hund_q == 8'h99 && sec_q == 8'h59 && min_q == 8'h59
         && hour_q[7] && hour_q[4:0] == 5'h11)
        |=> (hour_q[4:0] == 5'h12 && hour_q[5] != $past(hour_q[5])));
endmodule

// File: rtl/rtc_calendar_chain.sv
// Calendar counters: weekday, date, month and year, plus the stop and
// reset-enable bits. Advances once per day carry; month length from the BCD year.
// Assumes step is already gated by the stop bit and ld has priority.
module rtc_calendar_chain
    import bcd_rtc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             ld,
    input  logic             ld_osc,
    input  logic             ld_rsten,
    input  logic [2:0]       ld_dow,
    input  logic [REG_W-1:0] ld_date,
    input  logic [REG_W-1:0] ld_mon,
    input  logic [REG_W-1:0] ld_year,
    output logic             osc_q,
    output logic             rsten_q,
    output logic [2:0]       dow_q,
    output logic [REG_W-1:0] date_q,
    output logic [REG_W-1:0] mon_q,
    output logic [REG_W-1:0] year_q
);
    logic [REG_W-1:0] last_day;
    logic             c_mon, c_yr;

    // Month-end detection and carry ripple into month and year.
    always_comb begin
        last_day = month_last(mon_q, year_is_leap(year_q));
        c_mon    = step && (date_q >= last_day);
        c_yr     = c_mon && (mon_q >= 8'h12);
    end

    // Register update: reset, load, then day-carry advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_q   <= 1'b0;
            rsten_q <= 1'b0;
            dow_q   <= 3'd1;
            date_q  <= 8'h01;
            mon_q   <= 8'h01;
            year_q  <= 8'h00;
        end else if (ld) begin
            osc_q   <= ld_osc;
            rsten_q <= ld_rsten;
            dow_q   <= ld_dow;
            date_q  <= ld_date;
            mon_q   <= ld_mon;
            year_q  <= ld_year;
        end else begin
            if (step)  dow_q  <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
            if (step)  date_q <= c_mon ? 8'h01 : bcd_inc(date_q);
            if (c_mon) mon_q  <= (mon_q >= 8'h12) ? 8'h01 : bcd_inc(mon_q);
            if (c_yr)  year_q <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
    end

    // R8: weekday 7 followed by a day step becomes 1.
    p_dow_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && step && dow_q == 3'd7) |=> (dow_q == 3'd1));

    // R5: without a day step the date does not move.
    p_date_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !step) |=> $stable(date_q));

    // R7: year 99 at December 31 wraps to year 00.
    p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && step && date_q == 8'h31 && mon_q == 8'h12 && year_q == 8'h99)
        |=> (year_q == 8'h00 && mon_q == 8'h01));
endmodule

// File: rtl/rtc_snapshot.sv
// Snapshot register: copies the whole live word, byte by byte, in one edge on request.
// Assumes the live word only changes at clock edges.
module rtc_snapshot
    import bcd_rtc_pkg::*;
#(
    parameter int NB = NREG,
    parameter int BW = REG_W,
    localparam int W = NB * BW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic [W-1:0] live,
    output logic [W-1:0] snap
);
    for (genvar b = 0; b < NB; b++) begin : g_byte
        // Capture one byte of the live word.
        always_ff @(posedge clk) begin
            if (!rst_n)   snap[b*BW +: BW] <= '0;
            else if (req) snap[b*BW +: BW] <= live[b*BW +: BW];
        end
    end

    // R12: without a request the copy holds.
    p_snap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> $stable(snap));

    // R12: a request copies the live word from the request cycle.
    p_snap_take_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (snap == $past(live)));
endmodule

// File: rtl/bcd_rtc_core.sv
// Top level of the BCD clock calendar: masks the load word, gates the tick
// with the stop bit, chains the time and calendar counters and feeds the snapshot.
// Assumes tick is synchronous to clk and one cycle wide per hundredth.
module bcd_rtc_core
    import bcd_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    input  logic              snap_req,
    output logic [WORD_W-1:0] snap_data,
    output logic              osc_off,
    output logic              rst_en
);
    localparam logic [WORD_W-1:0] KEEP = word_mask();

    logic [REG_W-1:0]  ld_b [NREG];
    logic [REG_W-1:0]  hund, sec, mins, hour, date, mon, year;
    logic [2:0]        dow;
    logic              osc_q, rsten_q, adv, day_carry;
    logic [WORD_W-1:0] live;

    // Per-byte masking of the load word.
    for (genvar i = 0; i < NREG; i++) begin : g_ld
        assign ld_b[i] = load_data[i*REG_W +: REG_W] & keep_mask(i);
    end

    // Tick qualified by the stop bit.
    always_comb adv = tick && !osc_q;

    rtc_clock_chain u_clock (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .ld        (load_en),
        .ld_hund   (ld_b[IDX_HUND]),
        .ld_sec    (ld_b[IDX_SEC]),
        .ld_min    (ld_b[IDX_MIN]),
        .ld_hour   (ld_b[IDX_HOUR]),
        .hund_q    (hund),
        .sec_q     (sec),
        .min_q     (mins),
        .hour_q    (hour),
        .day_carry (day_carry)
    );

    rtc_calendar_chain u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (day_carry),
        .ld       (load_en),
        .ld_osc   (ld_b[IDX_CTL][5]),
        .ld_rsten (ld_b[IDX_CTL][4]),
        .ld_dow   (ld_b[IDX_CTL][2:0]),
        .ld_date  (ld_b[IDX_DATE]),
        .ld_mon   (ld_b[IDX_MON]),
        .ld_year  (ld_b[IDX_YEAR]),
        .osc_q    (osc_q),
        .rsten_q  (rsten_q),
        .dow_q    (dow),
        .date_q   (date),
        .mon_q    (mon),
        .year_q   (year)
    );

    // Assemble the live word in carry order.
    always_comb live = {year, mon, date, {2'b00, osc_q, rsten_q, 1'b0, dow},
                        hour, mins, sec, hund};

    rtc_snapshot #(.NB(NREG), .BW(REG_W)) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (snap_req),
        .live  (live),
        .snap  (snap_data)
    );

    // Control bits straight from the stored weekday byte.
    always_comb begin
        osc_off = osc_q;
        rst_en  = rsten_q;
    end

    // R9: with the stop bit set and no load, nothing moves.
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && osc_off) |=> $stable(live));

    // R11: a load wins over a tick in the same cycle.
    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (live == ($past(load_data) & KEEP)));

    // R10: unused bits never appear on the snapshot port.
    p_zero_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((snap_data & ~KEEP) == '0));
endmodule

// File: tb/bcd_rtc_core_tb_top.sv
// Directed bench: each task loads a word just before a boundary, ticks, and
// compares a snapshot with a value worked out from the requirements.
module bcd_rtc_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic        snap_req = 1'b0;
    logic [63:0] snap_data;
    logic        osc_off, rst_en;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    bcd_rtc_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load_en   (load_en),
        .load_data (load_data),
        .snap_req  (snap_req),
        .snap_data (snap_data),
        .osc_off   (osc_off),
        .rst_en    (rst_en)
    );

    function automatic logic [63:0] mk(input logic [7:0] yr, mo, da, ct, hr, mi, se, hu);
        return {yr, mo, da, ct, hr, mi, se, hu};
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] v);
        @(negedge clk);
        load_data = v;
        load_en   = 1'b1;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic do_read(output logic [63:0] v);
        @(negedge clk);
        snap_req = 1'b1;
        @(negedge clk);
        snap_req = 1'b0;
        v = snap_data;
    endtask

    task automatic one_step(input string req, input logic [63:0] start, input logic [63:0] exp);
        logic [63:0] got;
        do_load(start);
        do_ticks(1);
        do_read(got);
        chk(req, got, exp);
    endtask

    task automatic t_reset();
        logic [63:0] got;
        chk("R1 snap zero", snap_data, 64'h0);
        chk("R1 ctl low", {62'h0, osc_off, rst_en}, 64'h0);
        do_read(got);
        chk("R1 reset word", got, mk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_subhour();
        logic [63:0] got;
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h59, 8'h59, 8'h98));
        do_ticks(1);
        do_read(got);
        chk("R2 to 99", got, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h59, 8'h59, 8'h99));
        do_ticks(1);
        do_read(got);
        chk("R2 ripple to hour", got, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h06, 8'h00, 8'h00, 8'h00));
        one_step("R2 digit carry", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h10, 8'h20, 8'h09),
                 mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h10, 8'h20, 8'h10));
        one_step("R2 sec wrap", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h10, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h11, 8'h00, 8'h00));
    endtask

    task automatic t_24h();
        one_step("R3 midnight", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h16, 8'h04, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_12h();
        one_step("R4 11AM to 12PM", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h91, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h15, 8'h03, 8'hB2, 8'h00, 8'h00, 8'h00));
        one_step("R4 12PM to 01PM", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'hB2, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h15, 8'h03, 8'hA1, 8'h00, 8'h00, 8'h00));
        one_step("R4 11PM to 12AM", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'hB1, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h16, 8'h04, 8'h92, 8'h00, 8'h00, 8'h00));
        one_step("R4 12AM to 01AM", mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h92, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h81, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_months();
        one_step("R5 Apr 30", mk(8'h24, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h05, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R5 Nov 30", mk(8'h24, 8'h11, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h12, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R5 Jul 30", mk(8'h24, 8'h07, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h07, 8'h31, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R5 Jan 31", mk(8'h24, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h02, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_february();
        one_step("R6 y23 Feb 28", mk(8'h23, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h23, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R6 y24 Feb 28", mk(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R6 y24 Feb 29", mk(8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h24, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R6 y00 Feb 28", mk(8'h00, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h00, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R6 y10 Feb 28", mk(8'h10, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h10, 8'h03, 8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R6 y12 Feb 28", mk(8'h12, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h12, 8'h02, 8'h29, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_year_dow();
        one_step("R7 R8 y99 Dec 31 dow 7", mk(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
        one_step("R7 y45 Dec 31", mk(8'h45, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59, 8'h99),
                 mk(8'h46, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_stop();
        logic [63:0] got;
        logic [63:0] v;
        v = mk(8'h24, 8'h03, 8'h15, 8'h23, 8'h10, 8'h20, 8'h30, 8'h40);
        do_load(v);
        chk("R9 osc_off high", {63'h0, osc_off}, 64'h1);
        do_ticks(50);
        do_read(got);
        chk("R9 stopped", got, v);
    endtask

    task automatic t_zero_bits();
        logic [63:0] got;
        do_load(mk(8'h24, 8'hE3, 8'hD5, 8'hCB, 8'h45, 8'h90, 8'hA0, 8'h40));
        do_read(got);
        chk("R10 zero bits", got, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h10, 8'h20, 8'h40));
    endtask

    task automatic t_load_tick();
        logic [63:0] got;
        logic [63:0] v;
        v = mk(8'h31, 8'h08, 8'h09, 8'h02, 8'h07, 8'h33, 8'h44, 8'h55);
        @(negedge clk);
        load_data = v;
        load_en   = 1'b1;
        tick      = 1'b1;
        @(negedge clk);
        load_en   = 1'b0;
        tick      = 1'b0;
        do_read(got);
        chk("R11 load beats tick", got, v);
    endtask

    task automatic t_snapshot();
        logic [63:0] got;
        logic [63:0] v;
        v = mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h10, 8'h20, 8'h40);
        do_load(v);
        do_read(got);
        chk("R12 capture", got, v);
        do_ticks(30);
        @(negedge clk);
        chk("R12 hold", snap_data, v);
        do_read(got);
        chk("R12 recapture", got, mk(8'h24, 8'h03, 8'h15, 8'h03, 8'h05, 8'h10, 8'h20, 8'h70));
    endtask

    task automatic t_rst_en();
        do_load(mk(8'h24, 8'h03, 8'h15, 8'h13, 8'h05, 8'h10, 8'h20, 8'h40));
        chk("R13 rst_en and osc_off", {62'h0, osc_off, rst_en}, 64'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_subhour();
        t_24h();
        t_12h();
        t_months();
        t_february();
        t_year_dow();
        t_stop();
        t_zero_bits();
        t_load_tick();
        t_snapshot();
        t_rst_en();
        finish_run();
    end
endmodule